// File: doc/BRIEF.md
# NAND Flash Host Interface Sequencer

This block sits between an on-chip requester and an asynchronous byte-wide NAND flash part. It accepts one request at a time (page read, page program, block erase, or a plain status query) through a valid/ready handshake. It then produces every command, address and data bus cycle on the flash pins. Each cycle is marked by the command-latch and address-latch strobes and clocked by a write-enable or read-enable pulse.

Every AC limit is a parameter in nanoseconds. The block turns each one into a whole number of system clock cycles from the clock period, rounding up. Each strobe phase is timed by a down-counter. After the confirm opcode the sequencer waits on the open-drain ready line. It never uses a fixed delay there, and a timeout counter bounds the wait. Page data moves through byte-wide ports. The transfer runs from the requested column up to the last spare byte (column 2111 by default). After a program or an erase, the block reads the status byte and reports its bit 0 as the pass/fail result.

Top module: `nand_seq`

## Requirements
- R1: The command and address strobes are never high together. Write enable and read enable are never low together. Chip enable is low whenever either enable is low. The data bus is never driven while read enable is low.
- R2: A read (req_op 0) issues opcode 00h, then five address bytes in this order: column low, column high, row bits 7:0, row bits 15:8, row bits 17:16. It then issues opcode 30h.
- R3: A program (req_op 1) issues 80h, the five address bytes of R2, one data byte per wr_take pulse for each column from req_col to 2111 in order, and then 10h.
- R4: An erase (req_op 2) issues 60h, then only the three row bytes, then D0h.
- R5: The first program data write-enable pulse starts at least T_ADL_NS after the last address cycle.
- R6: The write-protect output is low whenever the block is idle. It goes high at least T_WW_NS before the first write-enable edge of a program or erase, and it stays high through the confirm opcode. It falls at least T_WW_NS before the next write-enable edge.
- R7: While the ready line is low, no write-enable or read-enable pulse occurs.
- R8: A read delivers 2112 minus req_col bytes on rd_data, one per rd_valid pulse, in column order.
- R9: After a program or erase, the block issues 70h and reads one byte. That byte appears on res_status, and res_fail equals its bit 0.
- R10: If the ready line stays low for TIMEOUT_CYC cycles, the request ends with res_timeout high and no status command is issued.
- R11: A status query (req_op 3) issues only 70h, then a status read, with no address cycles.
- R12: req_ready is high only while idle. done is a single-cycle pulse. After reset, chip enable, write enable and read enable are high and write protect is low.
- R13: Each write-enable low phase lasts at least T_WP_NS, and successive write-enable rising edges are at least T_WC_NS apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 status |
| req_row | input | PAGE_BITS+BLOCK_BITS | Block and page address |
| req_col | input | clog2(PAGE_BYTES) | First column to transfer |
| wr_data | input | 8 | Program data byte, valid while wr_take is high |
| wr_take | output | 1 | Consumes wr_data this cycle |
| rd_data | output | 8 | Read page byte |
| rd_valid | output | 1 | rd_data holds the next byte |
| done | output | 1 | Request finished (pulse) |
| res_fail | output | 1 | Bit 0 of the status byte |
| res_timeout | output | 1 | Ready line never returned |
| res_status | output | 8 | Last status byte read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_rb_n | input | 1 | Ready/busy, low while busy |
| nand_dq_out | output | 8 | Bus byte toward the flash |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus byte from the flash |

## Verification
The quiet-while-busy property assumes that the ready line falls no later than the rising write-enable edge of a confirm opcode and stays low until the part is done. The flash model in the bench drops it at exactly that edge. The address-to-data and write-protect checks assume that req_col stays below the page size, and that program data never arrives without a preceding address phase. The bench only issues legal columns, including the last one. Requests are raised only while req_ready is high, and the stuck-busy case is released before the next request.

// File: rtl/nand_seq_pkg.sv
// Shared types and helpers for the NAND sequencer.
// Assumes timing values are positive nanosecond counts.
package nand_seq_pkg;
    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_PROG   = 2'd1,
        OP_ERASE  = 2'd2,
        OP_STATUS = 2'd3
    } nand_op_e;

    typedef enum logic [1:0] {
        CY_CMD  = 2'd0,
        CY_ADDR = 2'd1,
        CY_DIN  = 2'd2,
        CY_DOUT = 2'd3
    } cyc_kind_e;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/nand_bus_cycle.sv
// One flash bus cycle: a write-enable pulse for command, address or data in,
// or a read-enable pulse that captures one byte. The low and high phases are
// timed by a down-counter. Assumes start is only raised while idle.
module nand_bus_cycle
    import nand_seq_pkg::*;
#(
    parameter int WE_LO = 1,
    parameter int WE_HI = 1,
    parameter int RE_LO = 2,
    parameter int RE_HI = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  cyc_kind_e  kind,
    input  logic [7:0] byte_in,
    output logic       done,
    output logic [7:0] rdata,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    input  logic [7:0] dq_in
);
    localparam int MAXC  = max2(max2(WE_LO, WE_HI), max2(RE_LO, RE_HI));
    localparam int CNT_W = $clog2(MAXC + 1);

    logic             active_q, low_q;
    logic [CNT_W-1:0] cnt_q;
    cyc_kind_e        kind_q;
    logic [7:0]       byte_q, rdata_q;
    logic             is_rd;

    assign is_rd = (kind_q == CY_DOUT);

    // Phase sequencing: low phase, then high phase, then back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            low_q    <= 1'b0;
            cnt_q    <= '0;
            kind_q   <= CY_CMD;
            byte_q   <= '0;
            rdata_q  <= '0;
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                low_q    <= 1'b1;
                kind_q   <= kind;
                byte_q   <= byte_in;
                cnt_q    <= (kind == CY_DOUT) ? CNT_W'(RE_LO - 1) : CNT_W'(WE_LO - 1);
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (low_q) begin
            low_q <= 1'b0;
            cnt_q <= is_rd ? CNT_W'(RE_HI - 1) : CNT_W'(WE_HI - 1);
            if (is_rd) rdata_q <= dq_in;
        end else begin
            active_q <= 1'b0;
        end
    end

    // Pin drive derived from the current phase.
    always_comb begin
        cle    = active_q && (kind_q == CY_CMD);
        ale    = active_q && (kind_q == CY_ADDR);
        we_n   = !(active_q && low_q && !is_rd);
        re_n   = !(active_q && low_q && is_rd);
        dq_oe  = active_q && !is_rd;
        dq_out = byte_q;
        done   = active_q && !low_q && (cnt_q == '0);
        rdata  = rdata_q;
    end
endmodule

// File: rtl/nand_busy_wait.sv
// Waits out the write-enable-to-busy guard, then polls the synchronised
// ready line until it is high or a cycle limit runs out. Assumes rb_n is
// asynchronous to clk.
module nand_busy_wait #(
    parameter int WB_CYC      = 5,
    parameter int TIMEOUT_CYC = 200000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rb_n,
    output logic ready,
    output logic timeout
);
    localparam int CNT_W = $clog2((WB_CYC > TIMEOUT_CYC ? WB_CYC : TIMEOUT_CYC) + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   guard_q, poll_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   rb_s;

    assign rb_s = sync_q[SYNC_STAGES-1];

    // Synchroniser chain for the ready line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rb_n};
    end

    // Guard interval followed by polling with a timeout count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_q <= 1'b0;
            poll_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            guard_q <= 1'b1;
            poll_q  <= 1'b0;
            cnt_q   <= CNT_W'(WB_CYC - 1);
        end else if (guard_q) begin
            if (cnt_q == '0) begin
                guard_q <= 1'b0;
                poll_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (poll_q) begin
            if (ready || timeout) poll_q <= 1'b0;
            else                  cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign ready   = poll_q && rb_s;
    assign timeout = poll_q && !rb_s && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/nand_seq.sv
// Top of the NAND host sequencer. It takes one request and runs its
// command, address, data, busy-wait and status phases through the
// bus-cycle engine, holding every AC limit as a counted number of cycles.
// Assumes req_col < PAGE_BYTES and that wr_data is valid whenever wr_take
// is high.
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int         CLK_PS      = 20000,
    parameter int         PAGE_BYTES  = 2112,
    parameter int         PAGE_BITS   = 6,
    parameter int         BLOCK_BITS  = 12,
    parameter int         T_WP_NS     = 15,
    parameter int         T_DS_NS     = 15,
    parameter int         T_WH_NS     = 10,
    parameter int         T_WC_NS     = 30,
    parameter int         T_RP_NS     = 15,
    parameter int         T_REA_NS    = 25,
    parameter int         T_REH_NS    = 10,
    parameter int         T_RC_NS     = 30,
    parameter int         T_ADL_NS    = 100,
    parameter int         T_WW_NS     = 100,
    parameter int         T_WB_NS     = 100,
    parameter int         T_WHR_NS    = 60,
    parameter int         T_RR_NS     = 20,
    parameter int         TIMEOUT_CYC = 200000,
    parameter logic [7:0] CMD_READ1   = 8'h00,
    parameter logic [7:0] CMD_READ2   = 8'h30,
    parameter logic [7:0] CMD_PROG1   = 8'h80,
    parameter logic [7:0] CMD_PROG2   = 8'h10,
    parameter logic [7:0] CMD_ERASE1  = 8'h60,
    parameter logic [7:0] CMD_ERASE2  = 8'hD0,
    parameter logic [7:0] CMD_STATUS  = 8'h70
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic [1:0]                      req_op,
    input  logic [PAGE_BITS+BLOCK_BITS-1:0] req_row,
    input  logic [$clog2(PAGE_BYTES)-1:0]   req_col,
    input  logic [7:0]                      wr_data,
    output logic                            wr_take,
    output logic [7:0]                      rd_data,
    output logic                            rd_valid,
    output logic                            done,
    output logic                            res_fail,
    output logic                            res_timeout,
    output logic [7:0]                      res_status,
    output logic                            nand_ce_n,
    output logic                            nand_cle,
    output logic                            nand_ale,
    output logic                            nand_we_n,
    output logic                            nand_re_n,
    output logic                            nand_wp_n,
    input  logic                            nand_rb_n,
    output logic [7:0]                      nand_dq_out,
    output logic                            nand_dq_oe,
    input  logic [7:0]                      nand_dq_in
);
    localparam int COL_W      = $clog2(PAGE_BYTES);
    localparam int ROW_W      = PAGE_BITS + BLOCK_BITS;
    localparam int COL_BYTES  = (COL_W + 7) / 8;
    localparam int ROW_BYTES  = (ROW_W + 7) / 8;
    localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
    localparam int IDX_W      = $clog2(ADDR_BYTES + 1);

    localparam int WE_LO   = max2(ns2cyc(T_WP_NS, CLK_PS), ns2cyc(T_DS_NS, CLK_PS));
    localparam int WE_HI   = max2(ns2cyc(T_WC_NS, CLK_PS) - WE_LO, ns2cyc(T_WH_NS, CLK_PS));
    localparam int RE_LO   = max2(ns2cyc(T_RP_NS, CLK_PS), ns2cyc(T_REA_NS, CLK_PS));
    localparam int RE_HI   = max2(ns2cyc(T_RC_NS, CLK_PS) - RE_LO, ns2cyc(T_REH_NS, CLK_PS));
    localparam int ADL_CYC = ns2cyc(T_ADL_NS, CLK_PS);
    localparam int WW_CYC  = ns2cyc(T_WW_NS, CLK_PS);
    localparam int WB_CYC  = ns2cyc(T_WB_NS, CLK_PS);
    localparam int WHR_CYC = ns2cyc(T_WHR_NS, CLK_PS);
    localparam int RR_CYC  = ns2cyc(T_RR_NS, CLK_PS);
    localparam int GAP_MAX = max2(max2(ADL_CYC, WW_CYC), max2(WHR_CYC, RR_CYC));
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_WPSET, S_CMD1, S_ADDR, S_ADL, S_DIN, S_CMD2, S_BUSY,
        S_RR, S_DOUT, S_SCMD, S_WHR, S_SRD, S_WPCLR, S_FIN
    } state_e;

    state_e                   state_q;
    nand_op_e                 op_q;
    logic [ROW_W-1:0]         row_q;
    logic [COL_W-1:0]         col_q;
    logic [IDX_W-1:0]         idx_q;
    logic [GAP_W-1:0]         gap_q;
    logic                     pend_q, wp_q, done_q, tmo_q, bw_start_q;
    logic [7:0]               status_q;
    logic [8*ADDR_BYTES-1:0]  addr_vec;
    logic                     bus_state, cyc_start, cyc_done;
    cyc_kind_e                cyc_kind;
    logic [7:0]               cyc_byte, cyc_rdata;
    logic                     bw_ready, bw_timeout;
    logic                     last_col, gap_zero;

    assign addr_vec = {(8*ROW_BYTES)'(row_q), (8*COL_BYTES)'(col_q)};
    assign last_col = (col_q == COL_W'(PAGE_BYTES - 1));
    assign gap_zero = (gap_q == '0);

    // Select which bus cycle the current state asks for.
    always_comb begin
        bus_state = 1'b1;
        cyc_kind  = CY_CMD;
        cyc_byte  = CMD_STATUS;
        unique case (state_q)
            S_CMD1: cyc_byte = (op_q == OP_READ) ? CMD_READ1 :
                               (op_q == OP_PROG) ? CMD_PROG1 : CMD_ERASE1;
            S_CMD2: cyc_byte = (op_q == OP_READ) ? CMD_READ2 :
                               (op_q == OP_PROG) ? CMD_PROG2 : CMD_ERASE2;
            S_ADDR: begin
                cyc_kind = CY_ADDR;
                cyc_byte = addr_vec[8*idx_q +: 8];
            end
            S_DIN: begin
                cyc_kind = CY_DIN;
                cyc_byte = wr_data;
            end
            S_DOUT, S_SRD: cyc_kind = CY_DOUT;
            S_SCMD: cyc_byte = CMD_STATUS;
            default: bus_state = 1'b0;
        endcase
    end

    assign cyc_start = bus_state && !pend_q;

    // Track a bus cycle in flight between its start and its done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (cyc_start) pend_q <= 1'b1;
        else if (cyc_done)  pend_q <= 1'b0;
    end

    // Request sequencing across command, address, data, wait and status phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= OP_READ;
            row_q      <= '0;
            col_q      <= '0;
            idx_q      <= '0;
            gap_q      <= '0;
            wp_q       <= 1'b0;
            done_q     <= 1'b0;
            tmo_q      <= 1'b0;
            status_q   <= '0;
            bw_start_q <= 1'b0;
        end else begin
            done_q     <= (state_q == S_FIN);
            bw_start_q <= 1'b0;
            if (!gap_zero) gap_q <= gap_q - 1'b1;
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    op_q     <= nand_op_e'(req_op);
                    row_q    <= req_row;
                    col_q    <= req_col;
                    tmo_q    <= 1'b0;
                    status_q <= '0;
                    idx_q    <= (nand_op_e'(req_op) == OP_ERASE) ? IDX_W'(COL_BYTES) : '0;
                    if (nand_op_e'(req_op) == OP_PROG || nand_op_e'(req_op) == OP_ERASE) begin
                        wp_q    <= 1'b1;
                        gap_q   <= GAP_W'(WW_CYC - 1);
                        state_q <= S_WPSET;
                    end else if (nand_op_e'(req_op) == OP_READ) begin
                        state_q <= S_CMD1;
                    end else begin
                        state_q <= S_SCMD;
                    end
                end
                S_WPSET: if (gap_zero) state_q <= S_CMD1;
                S_CMD1:  if (cyc_done) state_q <= S_ADDR;
                S_ADDR: if (cyc_done) begin
                    if (idx_q == IDX_W'(ADDR_BYTES - 1)) begin
                        if (op_q == OP_PROG) begin
                            gap_q   <= GAP_W'(ADL_CYC - 1);
                            state_q <= S_ADL;
                        end else begin
                            state_q <= S_CMD2;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                S_ADL: if (gap_zero) state_q <= S_DIN;
                S_DIN: if (cyc_done) begin
                    if (last_col) state_q <= S_CMD2;
                    else          col_q   <= col_q + 1'b1;
                end
                S_CMD2: if (cyc_done) begin
                    bw_start_q <= 1'b1;
                    state_q    <= S_BUSY;
                end
                S_BUSY: begin
                    if (bw_ready) begin
                        if (op_q == OP_READ) begin
                            gap_q   <= GAP_W'(RR_CYC - 1);
                            state_q <= S_RR;
                        end else begin
                            state_q <= S_SCMD;
                        end
                    end else if (bw_timeout) begin
                        tmo_q   <= 1'b1;
                        state_q <= wp_q ? S_WPCLR : S_FIN;
                        gap_q   <= GAP_W'(WW_CYC - 1);
                        wp_q    <= 1'b0;
                    end
                end
                S_RR: if (gap_zero) state_q <= S_DOUT;
                S_DOUT: if (cyc_done) begin
                    if (last_col) state_q <= S_FIN;
                    else          col_q   <= col_q + 1'b1;
                end
                S_SCMD: if (cyc_done) begin
                    gap_q   <= GAP_W'(WHR_CYC - 1);
                    state_q <= S_WHR;
                end
                S_WHR: if (gap_zero) state_q <= S_SRD;
                S_SRD: if (cyc_done) begin
                    status_q <= cyc_rdata;
                    state_q  <= wp_q ? S_WPCLR : S_FIN;
                    gap_q    <= GAP_W'(WW_CYC - 1);
                    wp_q     <= 1'b0;
                end
                S_WPCLR: if (gap_zero) state_q <= S_FIN;
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    nand_bus_cycle #(
        .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI)
    ) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cyc_start),
        .kind   (cyc_kind),
        .byte_in(cyc_byte),
        .done   (cyc_done),
        .rdata  (cyc_rdata),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .dq_out (nand_dq_out),
        .dq_oe  (nand_dq_oe),
        .dq_in  (nand_dq_in)
    );

    nand_busy_wait #(
        .WB_CYC(WB_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(2)
    ) u_bw (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (bw_start_q),
        .rb_n   (nand_rb_n),
        .ready  (bw_ready),
        .timeout(bw_timeout)
    );

    assign req_ready   = (state_q == S_IDLE);
    assign nand_ce_n   = (state_q == S_IDLE);
    assign nand_wp_n   = wp_q;
    assign wr_take     = (state_q == S_DIN) && cyc_start;
    assign rd_valid    = (state_q == S_DOUT) && cyc_done;
    assign rd_data     = cyc_rdata;
    assign done        = done_q;
    assign res_fail    = status_q[0];
    assign res_status  = status_q;
    assign res_timeout = tmo_q;
endmodule

// File: rtl/nand_seq_chk.sv
// Protocol checker for nand_seq, attached by bind. It watches only the
// flash pins and the host handshake. Assumes the ready line falls no later
// than the confirm write-enable rising edge.
module nand_seq_chk #(
    parameter int         ADL_CYC    = 5,
    parameter logic [7:0] CMD_PROG2  = 8'h10,
    parameter logic [7:0] CMD_ERASE2 = 8'hD0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic       wp_n,
    input logic       rb_n,
    input logic [7:0] dq_out,
    input logic       dq_oe,
    input logic       req_ready,
    input logic       done
);
    localparam int AW = $clog2(ADL_CYC + 2);
    logic [AW-1:0] adl_cnt;

    // Cycles elapsed since the address strobe was last high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || ale)                 adl_cnt <= '0;
        else if (adl_cnt != AW'(ADL_CYC))  adl_cnt <= adl_cnt + 1'b1;
    end

    assert_cle_ale_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    assert_we_re_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    assert_strobe_ce_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);
    assert_no_drive_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);
    assert_adl_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && dq_oe && !cle && !ale) |-> (adl_cnt >= AW'(ADL_CYC)));
    assert_wp_confirm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && cle && (dq_out == CMD_PROG2 || dq_out == CMD_ERASE2)) |-> wp_n);
    assert_wp_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !wp_n);
    assert_quiet_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_n |-> (we_n && re_n));
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ready_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ce_n);
endmodule

bind nand_seq nand_seq_chk #(
    .ADL_CYC(ADL_CYC), .CMD_PROG2(CMD_PROG2), .CMD_ERASE2(CMD_ERASE2)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (nand_ce_n),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .wp_n     (nand_wp_n),
    .rb_n     (nand_rb_n),
    .dq_out   (nand_dq_out),
    .dq_oe    (nand_dq_oe),
    .req_ready(req_ready),
    .done     (done)
);

// File: tb/sim_nand_seq.sv
// Bench: behavioural flash model on the pins plus request scenarios.
module sim_nand_seq;
    localparam int TOUT = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [17:0] req_row = '0;
    logic [11:0] req_col = '0;
    logic [7:0]  wr_data;
    logic        req_ready, wr_take, rd_valid, done, res_fail, res_timeout;
    logic [7:0]  rd_data, res_status;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        rb_m = 1'b1;

    nand_seq #(.TIMEOUT_CYC(TOUT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_row(req_row), .req_col(req_col),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .res_fail(res_fail), .res_timeout(res_timeout), .res_status(res_status),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .nand_rb_n(rb_m), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0] cmd_q[$];
    logic [7:0] addr_q[$];
    logic [7:0] data_q[$];
    logic [7:0] rd_got[$];
    int   busy_cycles = 30, busy_left = 0;
    bit   stuck = 0, stat_mode = 0, fail_bit = 0, data_seen = 0;
    int   rd_ptr = 0;
    logic [17:0] rd_row = '0;
    longint t_we_fall = 0, t_we_rise = 0, t_addr = 0, t_wp_rise = 0, t_wp_fall = 0;
    int   viol_we = 0, viol_adl = 0, viol_wp = 0, viol_busy = 0, viol_r1 = 0;
    int   wr_idx = 0;

    function automatic logic [7:0] page_byte(input logic [17:0] row, input int col);
        return 8'((col * 7 + int'(row[7:0])) & 255);
    endfunction

    function automatic logic [7:0] wr_pat(input int k);
        return 8'((k * 13 + 5) & 255);
    endfunction

    assign nand_dq_in = stat_mode ? (8'hC0 | {7'd0, fail_bit}) : page_byte(rd_row, rd_ptr);
    assign wr_data    = wr_pat(wr_idx);

    always @(posedge clk) if (wr_take) wr_idx <= wr_idx + 1;

    always @(negedge nand_we_n) begin
        t_we_fall = $time;
        if (!rb_m) viol_busy++;
    end
    always @(negedge nand_re_n) if (!rb_m) viol_busy++;
    always @(posedge nand_re_n) if (!stat_mode) rd_ptr++;
    always @(posedge nand_wp_n) t_wp_rise = $time;
    always @(negedge nand_wp_n) t_wp_fall = $time;

    always @(posedge nand_we_n) if (!nand_ce_n) begin
        if ($time - t_we_fall < 15) viol_we++;
        if (t_we_rise != 0 && $time - t_we_rise < 30) viol_we++;
        t_we_rise = $time;
        if (t_wp_fall != 0 && $time - t_wp_fall < 100) viol_wp++;
        if (nand_cle) begin
            cmd_q.push_back(nand_dq_out);
            case (nand_dq_out)
                8'h00: stat_mode = 0;
                8'h70: stat_mode = 1;
                8'h80, 8'h60: if (!nand_wp_n || $time - t_wp_rise < 100) viol_wp++;
                8'h30, 8'h10, 8'hD0: begin
                    if (nand_dq_out != 8'h30 && !nand_wp_n) viol_wp++;
                    if (nand_dq_out == 8'h30 && addr_q.size() == 5) begin
                        rd_ptr = {20'd0, addr_q[1][3:0], addr_q[0]};
                        rd_row = {addr_q[4][1:0], addr_q[3], addr_q[2]};
                    end
                    stat_mode = 0;
                    rb_m      = 1'b0;
                    busy_left = busy_cycles;
                end
                default: ;
            endcase
        end else if (nand_ale) begin
            addr_q.push_back(nand_dq_out);
            t_addr    = $time;
            data_seen = 0;
        end else begin
            if (!data_seen && $time - t_addr < 100) viol_adl++;
            data_seen = 1;
            data_q.push_back(nand_dq_out);
        end
    end

    always @(posedge clk) if (!rb_m && !stuck) begin
        if (busy_left <= 1) rb_m = 1'b1;
        else busy_left--;
    end

    // Per-clock pin rule monitor (R1).
    always @(negedge clk) if (rst_n) begin
        if (nand_cle && nand_ale) viol_r1++;
        if (!nand_we_n && !nand_re_n) viol_r1++;
        if ((!nand_we_n || !nand_re_n) && nand_ce_n) viol_r1++;
        if (!nand_re_n && nand_dq_oe) viol_r1++;
    end

    always @(negedge clk) if (rd_valid) rd_got.push_back(rd_data);

    // ---------------- scenarios ----------------
    task automatic run(input logic [1:0] op, input logic [17:0] row, input logic [11:0] col);
        cmd_q.delete(); addr_q.delete(); data_q.delete(); rd_got.delete();
        @(negedge clk);
        wr_idx    <= 0;
        req_op    = op; req_row = row; req_col = col;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic check_addr(input string req, input logic [7:0] exp[$]);
        check(addr_q.size() == exp.size(), req, "address count", addr_q.size(), exp.size());
        foreach (exp[i])
            if (i < addr_q.size() && addr_q[i] != exp[i])
                check(0, req, "address byte", addr_q[i], exp[i]);
    endtask

    task automatic check_cmds(input string req, input logic [7:0] exp[$]);
        check(cmd_q.size() == exp.size(), req, "command count", cmd_q.size(), exp.size());
        foreach (exp[i])
            if (i < cmd_q.size() && cmd_q[i] != exp[i])
                check(0, req, "command byte", cmd_q[i], exp[i]);
    endtask

    initial begin
        #(200000 * 20);
        check(0, "WATCHDOG", "run did not finish", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(nand_ce_n && nand_we_n && nand_re_n, "R12", "strobes idle after reset",
              {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        check(!nand_wp_n && req_ready && !done, "R12", "wp low, ready, no done",
              {nand_wp_n, req_ready, done}, 3'b010);

        // R2 R8: read near the page end
        busy_cycles = 40;
        run(2'd0, 18'h2A5C3, 12'd2100);
        check_cmds("R2", '{8'h00, 8'h30});
        check_addr("R2", '{8'h34, 8'h08, 8'hC3, 8'hA5, 8'h02});
        check(rd_got.size() == 12, "R8", "read byte count", rd_got.size(), 12);
        bad = 0;
        foreach (rd_got[i]) if (rd_got[i] != page_byte(18'h2A5C3, 2100 + i)) bad++;
        check(bad == 0, "R8", "read byte mismatches", bad, 0);

        // R8 boundary: last column only
        run(2'd0, 18'h00011, 12'd2111);
        check(rd_got.size() == 1, "R8", "last-column count", rd_got.size(), 1);
        check(rd_got.size() == 1 && rd_got[0] == page_byte(18'h00011, 2111), "R8",
              "last-column byte", rd_got.size() > 0 ? rd_got[0] : 0, page_byte(18'h00011, 2111));

        // R8 full page including spare area
        run(2'd0, 18'h00007, 12'd0);
        check(rd_got.size() == 2112, "R8", "full page count", rd_got.size(), 2112);
        bad = 0;
        foreach (rd_got[i]) if (rd_got[i] != page_byte(18'h00007, i)) bad++;
        check(bad == 0, "R8", "full page mismatches", bad, 0);

        // R3 R9: program, passing
        busy_cycles = 80; fail_bit = 0;
        run(2'd1, 18'h00105, 12'd2000);
        check_cmds("R3", '{8'h80, 8'h10, 8'h70});
        check_addr("R3", '{8'hD0, 8'h07, 8'h05, 8'h01, 8'h00});
        check(data_q.size() == 112, "R3", "program byte count", data_q.size(), 112);
        bad = 0;
        foreach (data_q[i]) if (data_q[i] != wr_pat(i)) bad++;
        check(bad == 0, "R3", "program byte mismatches", bad, 0);
        check(res_status == 8'hC0 && !res_fail, "R9", "program status pass",
              {res_fail, res_status}, 9'h0C0);
        check(!nand_wp_n, "R6", "wp low after program", nand_wp_n, 0);

        // R9: program reporting failure
        fail_bit = 1;
        run(2'd1, 18'h00200, 12'd2110);
        check(res_fail && res_status == 8'hC1, "R9", "program status fail",
              {res_fail, res_status}, 9'h1C1);

        // R4 R9: erase
        fail_bit = 0; busy_cycles = 150;
        run(2'd2, 18'h3FFC0, 12'd0);
        check_cmds("R4", '{8'h60, 8'hD0, 8'h70});
        check_addr("R4", '{8'hC0, 8'hFF, 8'h03});
        check(!res_fail && !res_timeout, "R9", "erase result", {res_fail, res_timeout}, 0);

        // R11: status query only
        fail_bit = 1;
        run(2'd3, 18'h00000, 12'd0);
        check_cmds("R11", '{8'h70});
        check(addr_q.size() == 0, "R11", "no address cycles", addr_q.size(), 0);
        check(res_status == 8'hC1, "R11", "status byte", res_status, 8'hC1);

        // R10: ready line stuck low
        fail_bit = 0; stuck = 1;
        run(2'd2, 18'h00040, 12'd0);
        check(res_timeout, "R10", "timeout flagged", res_timeout, 1);
        check_cmds("R10", '{8'h60, 8'hD0});
        stuck = 0; rb_m = 1'b1;
        check(!nand_wp_n && req_ready, "R6", "idle and protected after timeout",
              {nand_wp_n, req_ready}, 2'b01);

        // Pin-level rule counters accumulated over every scenario.
        check(viol_r1 == 0, "R1", "strobe rule violations", viol_r1, 0);
        check(viol_adl == 0, "R5", "address-to-data violations", viol_adl, 0);
        check(viol_wp == 0, "R6", "write-protect timing violations", viol_wp, 0);
        check(viol_busy == 0, "R7", "strobes while busy", viol_busy, 0);
        check(viol_we == 0, "R13", "write-enable timing violations", viol_we, 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule